// File: doc/BRIEF.md
# Turn and Tick Indexed Energy Monitor Buffer

This block keeps a rolling record of the final output energies of one trigger tower so that a host can inspect them afterwards. On every bunch tick the pipeline presents an electromagnetic (EM) and a hadronic (HD) energy byte. The block packs the two bytes into one 16-bit word and stores it at a location chosen by the current local turn number and tick number. The host never writes this buffer. It only reads it, through a separate read port.

The storage holds 1024 words. The location is not a linear pointer: the turn number selects one of four 256-word pages and the tick number selects a word inside the page. Only ticks 0 to 158 carry beam data, so 636 of the 1024 words are ever written. Strobes that carry a higher tick number are dropped. A capture-enable input stops all writing, so that software can read a frozen snapshot of the last four turns.

Top module: `tick_mon_buf`

## Requirements
- R1: A stored word holds the EM energy in bits 7..0 and the HD energy in bits 15..8.
- R2: The write location is {turn[1:0], tick[7:0]}: turn in address bits 9..8, tick in bits 7..0. The same tick in each of the four turns lands in four separate words.
- R3: On a rising clock edge where `rst_n`=1, `tick_vld`=1, `cap_en`=1 and `tick_num`<159, the packed word is written.
- R4: A strobe with `tick_num` of 159 or above writes nothing. Every location keeps its previous contents, including the location the strobe names and any location that shares its low tick bits.
- R5: While `cap_en`=0, no location changes.
- R6: `rd_data` shows the word at `rd_addr` as it stood at the previous rising edge, one clock after the address is presented.
- R7: When a read and a write hit the same location at the same edge, the read returns the contents before the write. The next read of that location returns the new word.
- R8: While `rst_n` is low, `rd_data` is 0 after each edge and no write takes place. The reset is synchronous and active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_en | input | 1 | Capture enable; 0 freezes the buffer |
| tick_vld | input | 1 | Tick strobe: energies and indices are valid |
| turn_num | input | 2 | Local turn number |
| tick_num | input | 8 | Tick number within the turn |
| em_et | input | 8 | EM output energy |
| hd_et | input | 8 | HD output energy |
| rd_addr | input | 10 | Host read word address |
| rd_data | output | 16 | Host read data, one clock latency |

## Verification
The bench checks the tick limit at 158, 159 and 255. If the comparison were off by one, word 159 would change. If the tick were truncated, a word at a lower tick would be overwritten, and the bench watches one such word. It writes the same tick in all four turns and reads all four words back, which catches a swapped or dropped turn field. It also sends strobes with capture disabled, which would expose a design that ignored the freeze. Same-cycle read and write of one location, both directed and random, catch a buffer that forwards new data where the old word is required. Checking reads on consecutive cycles exposes any wrong read latency.

// File: rtl/mon_pkg.sv
// Package: default sizes shared by the monitor buffer and its bench-facing checker.
// Assumes: one tower per buffer; the sizes below are defaults only.
package mon_pkg;
    localparam int MON_EW         = 8;    // width of one energy value
    localparam int MON_TURN_W     = 2;    // local turn number width
    localparam int MON_TICK_W     = 8;    // tick number width
    localparam int MON_TICKS_USED = 159;  // ticks per turn carrying data
endpackage

// File: rtl/mon_wr_ctrl.sv
// Module: mon_wr_ctrl
// Decides whether a tick strobe becomes a write, and forms the write location
// from the turn field (upper bits) and the tick field (lower bits).
// Assumes: TICKS_USED <= 2**TICK_W.
module mon_wr_ctrl #(
    parameter int TURN_W     = 2,
    parameter int TICK_W     = 8,
    parameter int TICKS_USED = 159,
    localparam int AW        = TURN_W + TICK_W
) (
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              tick_vld,
    input  logic [TURN_W-1:0] turn_num,
    input  logic [TICK_W-1:0] tick_num,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr
);
    localparam logic [TICK_W:0] LIMIT = (TICK_W+1)'(TICKS_USED);

    logic tick_in_range;

    // Qualify the strobe: out of reset, capture on, tick inside the data window.
    always_comb begin
        tick_in_range = ({1'b0, tick_num} < LIMIT);
        wr_en         = rst_n && cap_en && tick_vld && tick_in_range;
        wr_addr       = {turn_num, tick_num};
    end
endmodule

// File: rtl/mon_word_pack.sv
// Module: mon_word_pack
// Packs the per-tower energies into one word: lane 0 (low) is EM, lane 1 is HD.
// Assumes: both energies have the same width EW.
module mon_word_pack #(
    parameter int EW     = 8,
    localparam int LANES = 2,
    localparam int DW    = LANES * EW
) (
    input  logic [EW-1:0] em_et,
    input  logic [EW-1:0] hd_et,
    output logic [DW-1:0] word
);
    logic [EW-1:0] lane_val [LANES];

    // Map each energy onto its lane index.
    always_comb begin
        lane_val[0] = em_et;
        lane_val[1] = hd_et;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign word[g*EW +: EW] = lane_val[g];
    end
endmodule

// File: rtl/mon_dpram.sv
// Module: mon_dpram
// Simple dual-port storage: one write port and one registered read port.
// A read that collides with a write at the same edge returns the old word.
// Assumes: contents are not cleared by reset; only the read register is.
module mon_dpram #(
    parameter int AW     = 10,
    parameter int DW     = 16,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];

    // Store the word on a qualified write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Register the read word; the nonblocking update gives read-before-write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= mem[rd_addr];
        end
    end
endmodule

// File: rtl/tick_mon_buf.sv
// Module: tick_mon_buf (top)
// Records packed EM/HD energies per tick into a turn/tick indexed buffer and
// serves host reads with one clock of latency.
// Assumes: turn and tick counters are generated upstream and are valid with tick_vld.
module tick_mon_buf
    import mon_pkg::*;
#(
    parameter int EW         = MON_EW,
    parameter int TURN_W     = MON_TURN_W,
    parameter int TICK_W     = MON_TICK_W,
    parameter int TICKS_USED = MON_TICKS_USED,
    localparam int AW        = TURN_W + TICK_W,
    localparam int DW        = 2 * EW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              tick_vld,
    input  logic [TURN_W-1:0] turn_num,
    input  logic [TICK_W-1:0] tick_num,
    input  logic [EW-1:0]     em_et,
    input  logic [EW-1:0]     hd_et,
    input  logic [AW-1:0]     rd_addr,
    output logic [DW-1:0]     rd_data
);
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_word;

    mon_wr_ctrl #(
        .TURN_W(TURN_W), .TICK_W(TICK_W), .TICKS_USED(TICKS_USED)
    ) u_wr_ctrl (
        .rst_n(rst_n), .cap_en(cap_en), .tick_vld(tick_vld),
        .turn_num(turn_num), .tick_num(tick_num),
        .wr_en(wr_en), .wr_addr(wr_addr)
    );

    mon_word_pack #(.EW(EW)) u_pack (
        .em_et(em_et), .hd_et(hd_et), .word(wr_word)
    );

    mon_dpram #(.AW(AW), .DW(DW)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_word),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: rtl/tick_mon_buf_chk.sv
// Module: tick_mon_buf_chk
// Assertion checker bound to tick_mon_buf. It watches the top ports and the
// write request passed from the control and pack logic to the storage.
module tick_mon_buf_chk #(
    parameter int EW         = 8,
    parameter int TURN_W     = 2,
    parameter int TICK_W     = 8,
    parameter int TICKS_USED = 159,
    localparam int AW        = TURN_W + TICK_W,
    localparam int DW        = 2 * EW
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cap_en,
    input logic              tick_vld,
    input logic [TURN_W-1:0] turn_num,
    input logic [TICK_W-1:0] tick_num,
    input logic [EW-1:0]     em_et,
    input logic [EW-1:0]     hd_et,
    input logic [AW-1:0]     rd_addr,
    input logic [DW-1:0]     rd_data,
    input logic              wr_en,
    input logic [AW-1:0]     wr_addr,
    input logic [DW-1:0]     wr_word
);
    logic seen_edge;

    // Mark that at least one edge has passed, so that past values are meaningful.
    always_ff @(posedge clk) begin
        seen_edge <= 1'b1;
    end

    // R8: a reset cycle leaves the read register at zero.
    always_ff @(posedge clk) begin
        if (seen_edge && $past(!rst_n)) begin
            a_r8_reset_zero: assert (rd_data == '0);
        end
    end

    a_r1_packing: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_word[EW-1:0] == em_et && wr_word[DW-1:EW] == hd_et));

    a_r2_location: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_addr == {turn_num, tick_num});

    a_r4_high_tick_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, tick_num} >= (TICK_W+1)'(TICKS_USED)) |-> !wr_en);

    a_r5_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |-> !wr_en);

    a_r3_strobe_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_vld && cap_en && ({1'b0, tick_num} < (TICK_W+1)'(TICKS_USED))) |-> wr_en);

    a_r6_stable_read: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && rd_addr == $past(rd_addr) && !$past(wr_en)) |=> $stable(rd_data));
endmodule

bind tick_mon_buf tick_mon_buf_chk #(
    .EW(EW), .TURN_W(TURN_W), .TICK_W(TICK_W), .TICKS_USED(TICKS_USED)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .tick_vld(tick_vld),
    .turn_num(turn_num), .tick_num(tick_num), .em_et(em_et), .hd_et(hd_et),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_word(wr_word)
);

// File: tb/tick_mon_buf_test.sv
// Bench for tick_mon_buf: directed corner cases followed by seeded random traffic,
// compared against a reference array kept by the bench.
module tick_mon_buf_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_en = 1'b0;
    logic        tick_vld = 1'b0;
    logic [1:0]  turn_num = '0;
    logic [7:0]  tick_num = '0;
    logic [7:0]  em_et = '0;
    logic [7:0]  hd_et = '0;
    logic [9:0]  rd_addr = '0;
    logic [15:0] rd_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [15:0] ref_mem [1024];
    bit          ref_ok  [1024];

    bit          pend_ok = 1'b0;
    logic [15:0] pend_val = '0;
    string       pend_tag = "";

    always #2 clk = ~clk;  // 250 MHz

    tick_mon_buf uut (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .tick_vld(tick_vld),
        .turn_num(turn_num), .tick_num(tick_num), .em_et(em_et), .hd_et(hd_et),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [15:0] exp_word(logic [7:0] em, logic [7:0] hd);
        return {hd, em};
    endfunction

    function automatic logic [9:0] exp_loc(logic [1:0] turn, logic [7:0] tick);
        return {turn, tick};
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rd_data=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: check the previous read, drive inputs, update the reference.
    task automatic step(bit vld, bit cap, logic [1:0] turn, logic [7:0] tick,
                        logic [7:0] em, logic [7:0] hd, logic [9:0] ra, string tag);
        @(negedge clk);
        if (pend_ok) check(pend_tag, rd_data, pend_val);
        tick_vld = vld; cap_en = cap; turn_num = turn; tick_num = tick;
        em_et = em; hd_et = hd; rd_addr = ra;
        pend_ok  = ref_ok[ra] && rst_n;
        pend_val = ref_mem[ra];
        pend_tag = tag;
        if (rst_n && vld && cap && tick < 8'd159) begin
            ref_mem[exp_loc(turn, tick)] = exp_word(em, hd);
            ref_ok[exp_loc(turn, tick)]  = 1'b1;
        end
    endtask

    // Take whatever a never-written word holds as its reference value.
    task automatic learn(logic [9:0] a);
        step(0, 1, 0, 0, 0, 0, a, "R4");
        step(0, 1, 0, 0, 0, 0, a, "R4");
        #1;
        ref_mem[a] = rd_data;
        ref_ok[a]  = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            ref_ok[i]  = 1'b0;
            ref_mem[i] = '0;
        end
        void'($urandom(32'd20240));

        // R8: reset holds the read register at zero, strobes included.
        tick_vld = 1'b1; cap_en = 1'b1; tick_num = 8'd7; em_et = 8'h11;
        repeat (3) @(negedge clk);
        check("R8", rd_data, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        tick_vld = 1'b0;

        // R1: byte lanes.
        step(1, 1, 2'd0, 8'd10, 8'h3C, 8'hA5, 10'd0, "R1");
        step(0, 1, 0, 0, 0, 0, exp_loc(0, 10), "R1");
        step(0, 1, 0, 0, 0, 0, exp_loc(0, 10), "R1");

        // R2: same tick in all four turns.
        for (int t = 0; t < 4; t++)
            step(1, 1, 2'(t), 8'd20, 8'(8'h40 + t), 8'(8'hC0 + t), 10'd0, "R2");
        for (int t = 0; t < 4; t++)
            step(0, 1, 0, 0, 0, 0, exp_loc(2'(t), 8'd20), "R2");

        // R3: last valid tick is written.
        step(1, 1, 2'd3, 8'd158, 8'h5A, 8'h69, 10'd0, "R3");
        step(0, 1, 0, 0, 0, 0, exp_loc(3, 158), "R3");

        // R4: ticks 159 and 255 change nothing, including aliased low-tick words.
        learn(exp_loc(1, 159));
        learn(exp_loc(1, 255));
        step(1, 1, 2'd1, 8'd31, 8'h01, 8'h02, 10'd0, "R4");
        step(1, 1, 2'd1, 8'd127, 8'h03, 8'h04, 10'd0, "R4");
        step(1, 1, 2'd1, 8'd159, 8'hEE, 8'hDD, 10'd0, "R4");
        step(1, 1, 2'd1, 8'd255, 8'hBB, 8'hCC, 10'd0, "R4");
        step(0, 1, 0, 0, 0, 0, exp_loc(1, 159), "R4");
        step(0, 1, 0, 0, 0, 0, exp_loc(1, 255), "R4");
        step(0, 1, 0, 0, 0, 0, exp_loc(1, 31), "R4");
        step(0, 1, 0, 0, 0, 0, exp_loc(1, 127), "R4");

        // R5: strobes with capture off leave the word alone.
        step(1, 0, 2'd0, 8'd10, 8'h77, 8'h88, 10'd0, "R5");
        step(0, 0, 0, 0, 0, 0, exp_loc(0, 10), "R5");

        // R6: back-to-back reads of different words.
        step(0, 1, 0, 0, 0, 0, exp_loc(2, 20), "R6");
        step(0, 1, 0, 0, 0, 0, exp_loc(3, 158), "R6");

        // R7: same-edge read and write returns the old word, then the new one.
        step(1, 1, 2'd2, 8'd50, 8'h12, 8'h34, 10'd0, "R7");
        step(1, 1, 2'd2, 8'd50, 8'h56, 8'h78, exp_loc(2, 50), "R7");
        step(0, 1, 0, 0, 0, 0, exp_loc(2, 50), "R7");

        // Random traffic: reads often aim at the word being written.
        for (int n = 0; n < 4000; n++) begin
            bit          v = ($urandom % 4) != 0;
            bit          c = ($urandom % 8) != 0;
            logic [1:0]  tu = 2'($urandom);
            logic [7:0]  tk = 8'($urandom % 200);
            logic [9:0]  ra = ($urandom % 2) ? exp_loc(tu, tk) : 10'($urandom);
            string       tg = "R3";
            if (v && c && tk < 8'd159 && ra == exp_loc(tu, tk)) tg = "R7";
            else if (v && !c) tg = "R5";
            else if (tk >= 8'd159) tg = "R4";
            step(v, c, tu, tk, 8'($urandom), 8'($urandom), ra, tg);
        end
        step(0, 1, 0, 0, 0, 0, 10'd0, "R6");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule